// File: doc/BRIEF.md
# Per-Exception Floating-Point Result Post-Processor

This block sits at the end of a floating-point pipeline and decides what becomes of each finished result once its exception flags are known. Every one of the five IEEE 754 exceptions has its own 2-bit handling mode. Depending on the raised flags and their modes, the block does one of the following:
- lets the IEEE default result through;
- withholds the write and raises a trap request;
- replaces infinite or tiny results with finite ones;
- emits a result whose exponent has been wrapped back into range;
- suppresses the destination write and raises a flag that a conditional branch can test.

Upstream supplies three things: the IEEE default packed result, the unbounded biased exponent with the significand and sign, and the operation's exception flags. The flags come out one cycle later next to the final result.

A second operation kind, the wrap-count instruction, produces no result. It adjusts a signed counter by +1 or -1 according to whether the most recent arithmetic operation overflowed or underflowed. Software uses this counter to track how many times a long product or quotient has wrapped.

Top module: `fpp_exc_postproc`

## Requirements
- R1: Flag bit order is inexact=0, underflow=1, overflow=2, division-by-zero=3, invalid=4. The mode of exception i is in_mode[2i+1:2i], with codes 00 default, 01 signal, 10 finite, 11 wrap/inhibit. When no raised exception selects another action, the default result is written (out_wen=1). Inexact codes 10 and 11 also act as the default.
- R2: If any raised exception has mode 01, out_trap is 1 and out_wen is 0.
- R3: Overflow or division-by-zero in mode 10 turns an infinite default into the largest normal magnitude with the default's sign (exponent field all ones except bit 0, fraction all ones).
- R4: Underflow in mode 10 turns a default whose exponent field is zero into a zero with the default's sign.
- R5: Mode 10 never alters a NaN default. For invalid, mode 10 behaves as the default.
- R6: Overflow in mode 11 writes {in_sign, low EXP_W bits of (in_exp − B), in_frac}. Underflow in mode 11 uses (in_exp + B). B = 3·2^(EXP_W−2). Overflow wrapping takes priority.
- R7: Division-by-zero or invalid in mode 11 sets out_wen to 0 while out_flags still reports the raised flags.
- R8: br_inhibit is 1 exactly when the most recent arithmetic operation had an inhibited exception. A wrap-count operation or an idle cycle leaves it unchanged.
- R9: A wrap-count operation (in_op=1) adds 1 to wrap_count if the last arithmetic operation overflowed, subtracts 1 if it underflowed only, and otherwise leaves it unchanged. It produces no out_valid, out_wen or out_trap.
- R10: An arithmetic operation (in_op=0) gives out_valid=1 one cycle later, with out_flags equal to its in_flags.
- R11: After reset, out_valid, out_wen, out_trap, out_flags, br_inhibit and wrap_count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 1 | 0 arithmetic result, 1 wrap-count instruction |
| in_mode | input | 2*NEXC | Per-exception 2-bit handling modes |
| in_flags | input | NEXC | Current-exception flags of the operation |
| in_default | input | 1+EXP_W+FRAC_W | IEEE default packed result |
| in_sign | input | 1 | Sign of the exact result |
| in_exp | input | EXP_W+2 | Unbounded biased exponent, two's complement |
| in_frac | input | FRAC_W | Rounded fraction field |
| out_valid | output | 1 | Arithmetic result present |
| out_result | output | 1+EXP_W+FRAC_W | Final packed result |
| out_wen | output | 1 | Destination write enable |
| out_trap | output | 1 | Trap request |
| out_flags | output | NEXC | Flags travelling with the result |
| br_inhibit | output | 1 | Branch condition: last operation was inhibited |
| wrap_count | output | CNT_W | Signed wrap counter |

## Verification
A single operation can ask for a trap and an inhibited write at once, for example invalid in mode 11 together with inexact in mode 01. Wrapping or flushing can also coincide with a trap on another flag. The sweep provokes every such case by running all flag patterns against all mode words on a reduced format. For each one it judges whether trap and branch flag are both raised, whether the write is suppressed, and which result substitution wins. A separate sequence interleaves wrap-count and arithmetic operations, so that counter steps and branch-flag retention are checked against the operation that last set them.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
    localparam int NEXC  = 5;
    localparam int EX_NX = 0;
    localparam int EX_UF = 1;
    localparam int EX_OF = 2;
    localparam int EX_DZ = 3;
    localparam int EX_NV = 4;

    typedef enum logic [1:0] {
        MODE_IEEE    = 2'b00,
        MODE_SIGNAL  = 2'b01,
        MODE_FINITE  = 2'b10,
        MODE_WRAPINH = 2'b11
    } exc_mode_e;

    typedef enum logic {
        OP_ARITH   = 1'b0,
        OP_WRAPCNT = 1'b1
    } op_kind_e;

    typedef struct packed {
        logic trap;
        logic inhibit;
        logic wrap_of;
        logic wrap_uf;
        logic fin_big;
        logic fin_zero;
    } action_t;
endpackage

// File: rtl/fpp_mode_decode.sv
module fpp_mode_decode
    import fpp_pkg::*;
(
    input  logic [NEXC-1:0]   flags,
    input  logic [2*NEXC-1:0] modes,
    output action_t           act
);
    exc_mode_e       sel [NEXC];
    logic [NEXC-1:0] sig_hit;

    for (genvar i = 0; i < NEXC; i++) begin : g_exc
        assign sel[i]     = flags[i] ? exc_mode_e'(modes[2*i +: 2]) : MODE_IEEE;
        assign sig_hit[i] = (sel[i] == MODE_SIGNAL);
    end

    always_comb begin
        act          = '0;
        act.trap     = |sig_hit;
        act.inhibit  = (sel[EX_DZ] == MODE_WRAPINH) || (sel[EX_NV] == MODE_WRAPINH);
        act.wrap_of  = (sel[EX_OF] == MODE_WRAPINH);
        act.wrap_uf  = (sel[EX_UF] == MODE_WRAPINH);
        act.fin_big  = (sel[EX_OF] == MODE_FINITE) || (sel[EX_DZ] == MODE_FINITE);
        act.fin_zero = (sel[EX_UF] == MODE_FINITE);
    end
endmodule

// File: rtl/fpp_result_mux.sv
module fpp_result_mux
    import fpp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int XW    = EXP_W + 2
) (
    input  action_t         act,
    input  logic [W-1:0]    dflt,
    input  logic            sign,
    input  logic [XW-1:0]   exp_wide,
    input  logic [FRAC_W-1:0] frac,
    output logic [W-1:0]    res
);
    localparam logic [XW:0]  WBIAS  = (XW+1)'(3 << (EXP_W - 2));
    localparam logic [W-2:0] MAXMAG = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

    logic [XW:0]        ext, down, up;
    logic [EXP_W-1:0]   dexp;
    logic [FRAC_W-1:0]  dfrac;
    logic               is_inf, is_tiny;

    assign ext     = {exp_wide[XW-1], exp_wide};
    assign down    = ext - WBIAS;
    assign up      = ext + WBIAS;
    assign dexp    = dflt[W-2 -: EXP_W];
    assign dfrac   = dflt[FRAC_W-1:0];
    assign is_inf  = (dexp == {EXP_W{1'b1}}) && (dfrac == {FRAC_W{1'b0}});
    assign is_tiny = (dexp == {EXP_W{1'b0}});

    always_comb begin
        res = dflt;
        if (act.wrap_of)
            res = {sign, down[EXP_W-1:0], frac};
        else if (act.wrap_uf)
            res = {sign, up[EXP_W-1:0], frac};
        else if (act.fin_big && is_inf)
            res = {dflt[W-1], MAXMAG};
        else if (act.fin_zero && is_tiny)
            res = {dflt[W-1], {(W-1){1'b0}}};
    end
endmodule

// File: rtl/fpp_wrap_counter.sv
module fpp_wrap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             last_of,
    input  logic             last_uf,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (step_en) begin
            if (last_of)
                count <= count + 1'b1;
            else if (last_uf)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/fpp_exc_postproc.sv
module fpp_exc_postproc
    import fpp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int CNT_W  = 16,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int XW    = EXP_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic [2*NEXC-1:0] in_mode,
    input  logic [NEXC-1:0]   in_flags,
    input  logic [W-1:0]      in_default,
    input  logic              in_sign,
    input  logic [XW-1:0]     in_exp,
    input  logic [FRAC_W-1:0] in_frac,
    output logic              out_valid,
    output logic [W-1:0]      out_result,
    output logic              out_wen,
    output logic              out_trap,
    output logic [NEXC-1:0]   out_flags,
    output logic              br_inhibit,
    output logic [CNT_W-1:0]  wrap_count
);
    action_t      act;
    logic [W-1:0] mux_res;
    logic         fire_arith, fire_wrap;
    logic         last_of, last_uf;

    assign fire_arith = in_valid && (in_op == OP_ARITH);
    assign fire_wrap  = in_valid && (in_op == OP_WRAPCNT);

    fpp_mode_decode u_dec (
        .flags (in_flags),
        .modes (in_mode),
        .act   (act)
    );

    fpp_result_mux #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mux (
        .act      (act),
        .dflt     (in_default),
        .sign     (in_sign),
        .exp_wide (in_exp),
        .frac     (in_frac),
        .res      (mux_res)
    );

    fpp_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step_en (fire_wrap),
        .last_of (last_of),
        .last_uf (last_uf),
        .count   (wrap_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_wen    <= 1'b0;
            out_trap   <= 1'b0;
            out_flags  <= '0;
            br_inhibit <= 1'b0;
            last_of    <= 1'b0;
            last_uf    <= 1'b0;
        end else begin
            out_valid <= fire_arith;
            out_wen   <= fire_arith && !act.trap && !act.inhibit;
            out_trap  <= fire_arith && act.trap;
            out_flags <= fire_arith ? in_flags : '0;
            if (fire_arith) begin
                out_result <= mux_res;
                br_inhibit <= act.inhibit;
                last_of    <= in_flags[EX_OF];
                last_uf    <= in_flags[EX_UF];
            end
        end
    end
endmodule

// File: rtl/fpp_exc_postproc_chk.sv
module fpp_exc_postproc_chk
    import fpp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_op,
    input logic [2*NEXC-1:0] in_mode,
    input logic [NEXC-1:0]   in_flags,
    input logic              out_valid,
    input logic              out_wen,
    input logic              out_trap,
    input logic [NEXC-1:0]   out_flags,
    input logic              br_inhibit,
    input logic [CNT_W-1:0]  wrap_count
);
    a_r2_trap_blocks_write: assert property (@(posedge clk) disable iff (rst)
        out_trap |-> !out_wen);

    a_r7_invalid_inhibit: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && in_flags[EX_NV] && in_mode[2*EX_NV +: 2] == 2'b11)
        |=> (!out_wen && br_inhibit && out_flags[EX_NV]));

    a_r8_flag_kept_on_wrapcnt: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op) |=> $stable(br_inhibit));

    a_r9_wrapcnt_no_result: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op) |=> (!out_valid && !out_wen && !out_trap));

    a_r9_count_unit_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((wrap_count == $past(wrap_count)) ||
                  (wrap_count == $past(wrap_count) + 1'b1) ||
                  (wrap_count == $past(wrap_count) - 1'b1)));

    a_r9_count_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_op) |=> $stable(wrap_count));

    a_r10_flags_follow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op) |=> (out_valid && out_flags == $past(in_flags)));

    a_r10_quiet_when_invalid: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_wen && !out_trap));
endmodule

bind fpp_exc_postproc fpp_exc_postproc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_mode    (in_mode),
    .in_flags   (in_flags),
    .out_valid  (out_valid),
    .out_wen    (out_wen),
    .out_trap   (out_trap),
    .out_flags  (out_flags),
    .br_inhibit (br_inhibit),
    .wrap_count (wrap_count)
);

// File: tb/sim_fpp_exc_postproc.sv
module sim_fpp_exc_postproc;
    localparam int EXP_W  = 5;
    localparam int FRAC_W = 4;
    localparam int CNT_W  = 8;
    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int XW     = EXP_W + 2;
    localparam int B      = 3 << (EXP_W - 2);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_op = 1'b0;
    logic [9:0]        in_mode = '0;
    logic [4:0]        in_flags = '0;
    logic [W-1:0]      in_default = '0;
    logic              in_sign = 1'b0;
    logic [XW-1:0]     in_exp = '0;
    logic [FRAC_W-1:0] in_frac = '0;
    logic              out_valid, out_wen, out_trap, br_inhibit;
    logic [W-1:0]      out_result;
    logic [4:0]        out_flags;
    logic [CNT_W-1:0]  wrap_count;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    fpp_exc_postproc #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_mode(in_mode), .in_flags(in_flags), .in_default(in_default),
        .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac),
        .out_valid(out_valid), .out_result(out_result), .out_wen(out_wen),
        .out_trap(out_trap), .out_flags(out_flags), .br_inhibit(br_inhibit),
        .wrap_count(wrap_count)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pack(int s, int e, int f);
        return (s << (W-1)) | (e << FRAC_W) | f;
    endfunction

    task automatic arith(input int m, input int f, input int s, input int e,
                         input int fr, input int dflt);
        @(negedge clk);
        in_valid   = 1'b1;
        in_op      = 1'b0;
        in_mode    = 10'(m);
        in_flags   = 5'(f);
        in_sign    = s[0];
        in_exp     = XW'(e);
        in_frac    = FRAC_W'(fr);
        in_default = W'(dflt);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wrapcnt();
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_op    = 1'b0;
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 out_valid", out_valid, 0);
        chk("R11 out_wen", out_wen, 0);
        chk("R11 out_trap", out_trap, 0);
        chk("R11 out_flags", out_flags, 0);
        chk("R11 br_inhibit", br_inhibit, 0);
        chk("R11 wrap_count", wrap_count, 0);

        // Sweep: every mode word against every flag pattern
        for (int m = 0; m < 1024; m++) begin
            for (int f = 0; f < 32; f++) begin
                int md[5];
                int s, e, dflt, exp_res, trap, inh;
                for (int i = 0; i < 5; i++) md[i] = (m >> (2*i)) & 3;
                s = (m ^ f) & 1;
                if (f[4])                  dflt = pack(s, 31, 8);
                else if (f[2] || f[3])     dflt = pack(s, 31, 0);
                else if (f[1])             dflt = pack(s, 0, 3);
                else                       dflt = pack(s, 10, 5);
                e = f[2] ? 35 : (f[1] ? -3 : 10);
                trap = 0;
                for (int i = 0; i < 5; i++) if (f[i] && md[i] == 1) trap = 1;
                inh = (f[3] && md[3] == 3) || (f[4] && md[4] == 3);
                exp_res = dflt;
                if (f[2] && md[2] == 3)
                    exp_res = pack(s, (e - B) & 31, 9);
                else if (f[1] && md[1] == 3)
                    exp_res = pack(s, (e + B) & 31, 9);
                else if (((f[2] && md[2] == 2) || (f[3] && md[3] == 2)) && dflt == pack(s, 31, 0))
                    exp_res = pack(s, 30, 15);
                else if (f[1] && md[1] == 2 && ((dflt >> FRAC_W) & 31) == 0)
                    exp_res = pack(s, 0, 0);
                @(negedge clk);
                in_valid   = 1'b1;
                in_op      = 1'b0;
                in_mode    = 10'(m);
                in_flags   = 5'(f);
                in_sign    = s[0];
                in_exp     = XW'(e);
                in_frac    = 4'd9;
                in_default = W'(dflt);
                @(negedge clk);
                in_valid = 1'b0;
                chk("R10 out_valid/flags", {out_valid, out_flags}, {1'b1, 5'(f)});
                chk("R2 out_trap", out_trap, trap);
                chk("R7 out_wen", out_wen, (trap == 0 && inh == 0) ? 1 : 0);
                chk("R8 br_inhibit", br_inhibit, inh);
                if (out_wen)
                    chk("R1 R3 R4 R5 R6 out_result", out_result, exp_res);
            end
        end
        chk("R9 count untouched by arithmetic", wrap_count, 0);

        // Wrap counter and branch-flag retention
        arith(10'h0C0, 5'b00100, 0, 35, 9, pack(0, 31, 0));
        wrapcnt();
        chk("R9 overflow step", $signed(wrap_count), 1);
        chk("R9 no output on wrapcnt", {out_valid, out_wen, out_trap}, 0);
        wrapcnt();
        chk("R9 second overflow step", $signed(wrap_count), 2);
        arith(10'h00C, 5'b00010, 1, -3, 9, pack(1, 0, 3));
        wrapcnt(); wrapcnt(); wrapcnt();
        chk("R9 underflow steps", $signed(CNT_W'(wrap_count)), -1);
        arith(10'h000, 5'b00001, 0, 10, 9, pack(0, 10, 5));
        wrapcnt();
        chk("R9 no step when clean", $signed(wrap_count), -1);
        arith(10'h0C0, 5'b01000, 0, 10, 9, pack(0, 31, 0));
        chk("R7 divzero inhibited", {out_wen, br_inhibit}, 2'b01);
        wrapcnt();
        chk("R8 flag kept over wrapcnt", br_inhibit, 1);
        @(negedge clk);
        chk("R8 flag kept over idle", br_inhibit, 1);
        arith(10'h300, 5'b00000, 0, 10, 9, pack(0, 10, 5));
        chk("R8 flag cleared by clean op", br_inhibit, 0);
        chk("R1 clean op writes default", out_result, pack(0, 10, 5));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule